// File: doc/BRIEF.md
# Sparse LUT-Input Crossbar

This block feeds the pins of a cluster of lookup tables from a bundle of routing tracks. Every LUT pin is one output. Each output is a small multiplexer that can reach only a fixed handful of tracks, not the whole bundle. The set of tracks each output can reach is computed during elaboration from the parameters. The pattern is built so that three properties hold:

- every track is offered to about the same number of pins;
- every pin sees the same number of tracks;
- two pins share as few tracks as possible.

The select value of each multiplexer is loaded over a one-bit serial chain. The outputs stay low until the whole chain has been filled once since reset.

The tracks are split into `FAN` groups of `GRP = NTRACK/FAN` tracks each. Output `j` takes one tap from each group. Within group `c` its position is `(j mod GRP) + (j div GRP)*c`, reduced mod `GRP`. Each output is therefore a line with its own offset and its own slope.

When `GRP` is prime and `NOUT <= GRP*GRP`, two lines with different slopes cross at most once, and two lines with the same slope never cross. The defaults are 104 tracks, 8 LUTs, 4 pins per LUT and 8 taps per pin, which gives `GRP` = 13.

Top module: `sparse_xbar`

## Requirements
- R1: After reset every bit of `lut_in` is 0, whatever the tracks carry.
- R2: A clock edge with `cfg_en` high shifts `cfg_bit` into the chain. The first bit sent ends up as the LSB of output 0's select. Output `j`'s select is made of bits `j*SELW` to `j*SELW+SELW-1` in sending order, so the order is output 0 first, LSB first. `SELW = clog2(FAN+1)`, which is 4 by default.
- R3: All outputs stay 0 until `NOUT*SELW` shift edges (128 by default) have occurred since reset. After that they follow their selects, including while a later reload is under way.
- R4: While `cfg_en` is low the chain keeps its contents and `cfg_bit` has no effect.
- R5: With select code `c < FAN`, output `j` equals the track at index `c*GRP + ((j mod GRP) + (j div GRP)*c) mod GRP`.
- R6: Select codes from `FAN` to `2^SELW-1` drive the output to a constant 0.
- R7: Each track is reachable from between floor and ceil of `NOUT*FAN/NTRACK` outputs (2 or 3 by default).
- R8: Each output reaches exactly `FAN` distinct tracks.
- R9: Any two distinct outputs share at most one track, so their connection columns differ in at least `2*FAN-2` positions.
- R10: Every output applies its own select at the same time as all the others. A mix of codes, some valid and some unused, gives each output its own choice on the same track pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the select chain |
| cfg_bit | input | 1 | Serial select data |
| tracks | input | NTRACK | Routing track values |
| lut_in | output | NLUT*KIN | LUT pin values; output `lut*KIN + pin` |

## Verification
The bench measures the real connectivity at the ports. It sets every select to one code, walks a single 1 across all tracks, and records which outputs respond. From that map it checks the group formula, the per-track and per-output balance, and the at-most-one-shared-track rule. A generator with a wrong slope or offset would show up as an unbalanced track or as a pair of outputs sharing several tracks.

Other corner cases are checked one by one:

- **127th shift edge:** a load counter that is off by one would release the outputs here.
- **Idle cycles with `cfg_bit` held high:** a chain that shifts without `cfg_en` would push a high bit into the select of output 31 (the last output), turning it into an unused code.
- **Unused codes:** a design that wrapped an unused code onto a real tap would pass a track instead of 0.
- **Mixed codes:** a mixed load exposes a reversed or misaligned chain order.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Track reached by tap c of output j: group c, rotated by the output's slope.
    function automatic int tap_track(input int j, input int c, input int grp);
        int offs;
        int slope;
        offs  = j % grp;
        slope = j / grp;
        return c * grp + ((offs + slope * c) % grp);
    endfunction

endpackage

// File: rtl/xbar_cfg_chain.sv
module xbar_cfg_chain #(
    parameter int CHAIN = 128,
    localparam int CNTW = $clog2(CHAIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [CHAIN-1:0] sel_flat,
    output logic             loaded
);

    typedef struct packed {
        logic [CHAIN-1:0] chain;
        logic [CNTW-1:0]  cnt;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.chain = {cfg_bit, st_q.chain[CHAIN-1:1]};
            if (st_q.cnt != CNTW'(CHAIN)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_flat = st_q.chain;
    assign loaded   = (st_q.cnt == CNTW'(CHAIN));

endmodule

// File: rtl/xbar_tap_mux.sv
module xbar_tap_mux #(
    parameter int FAN  = 8,
    parameter int SELW = 4
) (
    input  logic [FAN-1:0]  cand,
    input  logic [SELW-1:0] sel,
    input  logic            en,
    output logic            y
);

    always_comb begin
        y = 1'b0;
        for (int t = 0; t < FAN; t++) begin
            if (en && (sel == SELW'(t))) begin
                y = cand[t];
            end
        end
    end

endmodule

// File: rtl/sparse_xbar.sv
module sparse_xbar #(
    parameter int NLUT   = 8,
    parameter int KIN    = 4,
    parameter int FAN    = 8,
    parameter int NTRACK = 104
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic                  cfg_bit,
    input  logic [NTRACK-1:0]     tracks,
    output logic [NLUT*KIN-1:0]   lut_in
);

    localparam int NOUT  = NLUT * KIN;
    localparam int GRP   = NTRACK / FAN;
    localparam int SELW  = $clog2(FAN + 1);
    localparam int CHAIN = NOUT * SELW;

    logic [CHAIN-1:0] sel_flat;
    logic             loaded;

    xbar_cfg_chain #(.CHAIN(CHAIN)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_bit  (cfg_bit),
        .sel_flat (sel_flat),
        .loaded   (loaded)
    );

    for (genvar j = 0; j < NOUT; j++) begin : g_out
        logic [FAN-1:0] cand;
        for (genvar t = 0; t < FAN; t++) begin : g_tap
            localparam int TRK = xbar_pkg::tap_track(j, t, GRP);
            assign cand[t] = tracks[TRK];
        end
        xbar_tap_mux #(.FAN(FAN), .SELW(SELW)) i_mux (
            .cand (cand),
            .sel  (sel_flat[j*SELW +: SELW]),
            .en   (loaded),
            .y    (lut_in[j])
        );
    end

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
    parameter int CHAIN = 128,
    parameter int NOUT  = 32,
    parameter int SELW  = 4,
    parameter int FAN   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_bit,
    input logic [CHAIN-1:0] sel_flat,
    input logic [NOUT-1:0]  lut_in
);

    localparam int CW = $clog2(CHAIN + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (cfg_en && seen_q != CW'(CHAIN)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_hold_until_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != CW'(CHAIN)) |-> (lut_in == '0));

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (sel_flat[CHAIN-1] == $past(cfg_bit)));

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(sel_flat));

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == CW'(CHAIN) && int'(sel_flat[SELW-1:0]) >= FAN) |-> (lut_in[0] == 1'b0));

endmodule

bind sparse_xbar xbar_chk #(
    .CHAIN (CHAIN),
    .NOUT  (NOUT),
    .SELW  (SELW),
    .FAN   (FAN)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_bit  (cfg_bit),
    .sel_flat (sel_flat),
    .lut_in   (lut_in)
);

// File: tb/test_sparse_xbar.sv
`timescale 1ns/1ps
module test_sparse_xbar;

    localparam int NLUT   = 8;
    localparam int KIN    = 4;
    localparam int FAN    = 8;
    localparam int NTRACK = 104;
    localparam int NOUT   = NLUT * KIN;
    localparam int GRP    = NTRACK / FAN;
    localparam int SELW   = 4;
    localparam int CHAIN  = NOUT * SELW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_en = 1'b0;
    logic              cfg_bit = 1'b0;
    logic [NTRACK-1:0] tracks = '0;
    logic [NOUT-1:0]   lut_in;

    always #10 clk = ~clk;

    sparse_xbar #(.NLUT(NLUT), .KIN(KIN), .FAN(FAN), .NTRACK(NTRACK)) i_sparse_xbar (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .tracks(tracks), .lut_in(lut_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [NOUT-1:0] exp_q[$];
    string           tag_q[$];
    int              trk_q[$];
    bit              obs[NOUT][NTRACK];
    int              codes[NOUT];

    function automatic int ref_tap(int j, int c);
        return c * GRP + (((j % GRP) + (j / GRP) * c) % GRP);
    endfunction

    function automatic logic [CHAIN-1:0] pack_codes();
        logic [CHAIN-1:0] v;
        for (int j = 0; j < NOUT; j++) v[j*SELW +: SELW] = SELW'(codes[j]);
        return v;
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    task automatic note(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // driver: apply stimulus and queue the expected output
    task automatic apply(logic [NTRACK-1:0] v, logic [NOUT-1:0] e, string tg, int tr);
        @(posedge clk); #1;
        tracks = v;
        exp_q.push_back(e);
        tag_q.push_back(tg);
        trk_q.push_back(tr);
    endtask

    task automatic load(logic [CHAIN-1:0] v, int first, int nb);
        for (int i = first; i < first + nb; i++) begin
            @(posedge clk); #1;
            cfg_en = 1'b1;
            cfg_bit = v[i];
        end
        @(posedge clk); #1;
        cfg_en = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NOUT-1:0] e;
            string tg;
            int tr;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            tr = trk_q.pop_front();
            n_chk++;
            if (lut_in !== e) begin
                n_fail++;
                $display("FAIL %s: lut_in=%h expected=%h", tg, lut_in, e);
            end
            if (tr >= 0) begin
                for (int j = 0; j < NOUT; j++) if (lut_in[j] === 1'b1) obs[j][tr] = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [CHAIN-1:0] v;
        logic [NTRACK-1:0] tv;
        logic [NOUT-1:0] e;
        tracks = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        apply('1, '0, "R1 reset outputs low", -1);

        // all codes 0, stop one bit short of a full chain
        for (int j = 0; j < NOUT; j++) codes[j] = 0;
        v = pack_codes();
        load(v, 0, CHAIN - 1);
        apply('1, '0, "R3 held low one bit short", -1);

        // idle with cfg_bit high: must not shift or count
        cfg_bit = 1'b1;
        repeat (20) @(posedge clk);
        apply('1, '0, "R4 idle does not count", -1);
        load(v, CHAIN - 1, 1);
        apply('1, '1, "R3 released after full chain / R4 chain intact", -1);
        cfg_bit = 1'b1;
        repeat (20) @(posedge clk);
        apply('1, '1, "R4 idle after load", -1);

        // connectivity sweep, one code at a time
        for (int c = 0; c < FAN; c++) begin
            for (int j = 0; j < NOUT; j++) codes[j] = c;
            load(pack_codes(), 0, CHAIN);
            for (int r = 0; r < NTRACK; r++) begin
                tv = '0;
                tv[r] = 1'b1;
                for (int j = 0; j < NOUT; j++) e[j] = (ref_tap(j, c) == r);
                apply(tv, e, "R5 tap sweep", r);
            end
        end

        // unused codes
        for (int j = 0; j < NOUT; j++) codes[j] = FAN + (j % ((1 << SELW) - FAN));
        load(pack_codes(), 0, CHAIN);
        apply('1, '0, "R6 unused codes all ones", -1);
        apply({NTRACK/2{2'b10}}, '0, "R6 unused codes pattern", -1);

        // mixed per-output codes with random tracks
        for (int j = 0; j < NOUT; j++) codes[j] = (j * 5 + 3) % (1 << SELW);
        load(pack_codes(), 0, CHAIN);
        for (int n = 0; n < 24; n++) begin
            for (int b = 0; b < NTRACK; b++) tv[b] = 1'($urandom % 2);
            for (int j = 0; j < NOUT; j++)
                e[j] = (codes[j] < FAN) ? tv[ref_tap(j, codes[j])] : 1'b0;
            apply(tv, e, "R10 mixed selects / R2 chain order", -1);
        end

        wait (exp_q.size() == 0);
        @(negedge clk); #1;

        // balance and distance from the measured map
        for (int j = 0; j < NOUT; j++) begin
            int cnt;
            cnt = 0;
            for (int r = 0; r < NTRACK; r++) cnt += obs[j][r];
            note(cnt == FAN, "R8 output fan", cnt, FAN);
        end
        begin
            int lo;
            int hi;
            lo = (NOUT * FAN) / NTRACK;
            hi = lo + (((NOUT * FAN) % NTRACK) != 0 ? 1 : 0);
            for (int r = 0; r < NTRACK; r++) begin
                int cnt;
                cnt = 0;
                for (int j = 0; j < NOUT; j++) cnt += obs[j][r];
                note(cnt >= lo && cnt <= hi, "R7 track balance", cnt, hi);
            end
        end
        for (int a = 0; a < NOUT; a++) begin
            for (int b = a + 1; b < NOUT; b++) begin
                int sh;
                sh = 0;
                for (int r = 0; r < NTRACK; r++) sh += (obs[a][r] && obs[b][r]) ? 1 : 0;
                note(sh <= 1, "R9 pair overlap", sh, 1);
            end
        end

        report();
        $finish;
    end

endmodule